// File: doc/BRIEF.md
# IDE Programmed-I/O Cycle Timing Engine

This block turns single register or data transfers requested on a host-side port into programmed-I/O command cycles on a parallel ATA device cable. Each request carries a register address, a read/write flag, a flag marking the data register, a control-block select, a drive number and write data. The engine drives the three address lines and the two active-low chip selects. It gives them setup time, then asserts the read or the write strobe for a programmed width. It stretches that strobe while the device holds IORDY low, and finally holds the lines through a recovery interval. Read data is returned together with a one-clock done pulse.

Each of the two drives has its own timing selection. When a drive's fast timing is enabled, data-register accesses use a programmable strobe width and recovery time. All other register accesses always use a slower fixed timing. A data-register access that follows another one at the same address does not repeat the address setup. The engine goes straight from the previous recovery into the next strobe. IORDY passes through a two-flop synchronizer, so a stretch is never shorter than two extra clocks.

Top module: `ide_pio_engine`

## Requirements
- R1: Under reset and right after it, both strobes are high, both chip selects are high (`ide_cs_n` = 2'b11), `rsp_done` is low and `req_ready` is high. A reset during a cycle returns the outputs to this state on the next clock.
- R2: A request accepted while idle gets exactly 2 clocks of setup before its strobe falls. `ide_da` equals `req_addr` during setup and strobe, and the chip selects stay stable. `ide_cs_n` is 2'b10 when `req_ctl_blk` is 0 and 2'b01 when it is 1.
- R3: A data-register access (`req_data_port`=1) to a drive whose `cfg_fast_en` bit is set holds its strobe for `cfg_strb_sel`[2d+1:2d] + 2 clocks (2 to 5) when IORDY stays high.
- R4: After the strobe, such an access spends `cfg_rcv_sel`[2d+1:2d] + 1 clocks (1 to 4) in recovery. `rsp_done` is high for exactly one clock, the last clock of recovery.
- R5: A non-data register access always uses 5 strobe clocks and 4 recovery clocks, whatever the fast-timing settings are.
- R6: The timing is selected by `req_drive`. A drive with fast timing disabled uses 5/4 clocks even for data-register accesses, and each drive's fields act only on that drive.
- R7: A data-register request accepted in the last recovery clock of a data-register access with the same address and chip select starts its strobe on the next clock with no setup. Any other request accepted there gets the 2-clock setup.
- R8: If the synchronized IORDY is low on the last programmed strobe clock, the strobe is extended by at least 2 clocks. It is released on the first clock on which the synchronized IORDY is high and the minimum stretch has elapsed.
- R9: IORDY going low and back high early enough that its synchronized copy is high again on the last programmed strobe clock adds no wait clocks.
- R10: Reads use only `ide_dior_n` and writes only `ide_diow_n`, and the two are never low together. A write drives `req_wdata` on `ide_dd_out` with `ide_dd_oe` high. A read returns the `ide_dd_in` value present at the clock edge that raises the strobe, on `rsp_rdata` while `rsp_done` is high.
- R11: `req_ready` is high only while idle or in the last recovery clock. Requests are accepted only then.
- R12: When no request is accepted at the end of recovery, the next clock returns both chip selects high and `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can take a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_port | input | 1 | Request targets the data register |
| req_drive | input | DRV_W | Drive whose timing applies |
| req_ctl_blk | input | 1 | 0 = command block select, 1 = control block select |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| cfg_fast_en | input | 2**DRV_W | Per-drive fast timing enable |
| cfg_strb_sel | input | 2*2**DRV_W | Per-drive strobe width code, 2 bits per drive |
| cfg_rcv_sel | input | 2*2**DRV_W | Per-drive recovery code, 2 bits per drive |
| ide_da | output | ADDR_W | Device address lines |
| ide_cs_n | output | 2 | Active-low chip selects, bit 0 command block |
| ide_dior_n | output | 1 | Active-low read strobe |
| ide_diow_n | output | 1 | Active-low write strobe |
| ide_dd_out | output | DATA_W | Write data to the cable |
| ide_dd_oe | output | 1 | Data output enable |
| ide_dd_in | input | DATA_W | Read data from the cable |
| ide_iordy | input | 1 | Device ready, asynchronous |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |

## Verification
The properties assume that a request held on the port stays unchanged until it is accepted. They also assume that IORDY moves only while the engine is not sampling it in a way that could make the device look permanently not ready. The bench changes the request fields and configuration only on falling edges while the engine is idle, or in the recovery clocks of a back-to-back pair. It pulls IORDY low only inside a strobe and always releases it within a bounded number of clocks. Read data is applied before each transfer begins and held until its done pulse.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_STRB  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_RECOV = 3'd4
    } phase_e;

    localparam int unsigned SEL_W       = 2;  // width of each timing code
    localparam int unsigned CNT_W       = 3;  // holds lengths minus one, up to 4
    localparam int unsigned STRB_BASE   = 2;  // fast strobe = code + 2
    localparam int unsigned RCV_BASE    = 1;  // fast recovery = code + 1
    localparam int unsigned COMPAT_STRB = 5;
    localparam int unsigned COMPAT_RCV  = 4;
    localparam int unsigned SETUP_CLKS  = 2;
    localparam int unsigned WAIT_MIN    = 2;  // shortest IORDY stretch
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/ide_pio_sync.sv
module ide_pio_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/ide_pio_timing.sv
module ide_pio_timing
    import ide_pio_pkg::*;
#(
    parameter  int unsigned DRV_W   = 1,
    localparam int unsigned NUM_DRV = 1 << DRV_W
) (
    input  logic [NUM_DRV-1:0]       fast_en,
    input  logic [NUM_DRV*SEL_W-1:0] strb_sel,
    input  logic [NUM_DRV*SEL_W-1:0] rcv_sel,
    input  logic [DRV_W-1:0]         drive,
    input  logic                     data_port,
    output logic [CNT_W-1:0]         strb_last,
    output logic [CNT_W-1:0]         rcv_last
);
    logic [CNT_W-1:0] drv_strb [NUM_DRV];
    logic [CNT_W-1:0] drv_rcv  [NUM_DRV];

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
        assign drv_strb[g] = fast_en[g]
            ? CNT_W'(STRB_BASE - 1) + CNT_W'(strb_sel[g*SEL_W +: SEL_W])
            : CNT_W'(COMPAT_STRB - 1);
        assign drv_rcv[g]  = fast_en[g]
            ? CNT_W'(RCV_BASE - 1) + CNT_W'(rcv_sel[g*SEL_W +: SEL_W])
            : CNT_W'(COMPAT_RCV - 1);
    end

    assign strb_last = data_port ? drv_strb[drive] : CNT_W'(COMPAT_STRB - 1);
    assign rcv_last  = data_port ? drv_rcv[drive]  : CNT_W'(COMPAT_RCV - 1);
endmodule

// File: rtl/ide_pio_engine.sv
module ide_pio_engine
    import ide_pio_pkg::*;
#(
    parameter  int unsigned DATA_W  = 16,
    parameter  int unsigned ADDR_W  = 3,
    parameter  int unsigned DRV_W   = 1,
    localparam int unsigned NUM_DRV = 1 << DRV_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic                     req_data_port,
    input  logic [DRV_W-1:0]         req_drive,
    input  logic                     req_ctl_blk,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [NUM_DRV-1:0]       cfg_fast_en,
    input  logic [NUM_DRV*SEL_W-1:0] cfg_strb_sel,
    input  logic [NUM_DRV*SEL_W-1:0] cfg_rcv_sel,
    output logic [ADDR_W-1:0]        ide_da,
    output logic [1:0]               ide_cs_n,
    output logic                     ide_dior_n,
    output logic                     ide_diow_n,
    output logic [DATA_W-1:0]        ide_dd_out,
    output logic                     ide_dd_oe,
    input  logic [DATA_W-1:0]        ide_dd_in,
    input  logic                     ide_iordy,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata
);
    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  strb_last;
        logic [CNT_W-1:0]  rcv_last;
        logic              write;
        logic              dport;
        logic [ADDR_W-1:0] da;
        logic [1:0]        cs_n;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              dior_n;
        logic              diow_n;
    } eng_t;

    localparam eng_t ENG_RST = '{
        phase: ST_IDLE, cnt: '0, strb_last: '0, rcv_last: '0, write: 1'b0,
        dport: 1'b0, da: '0, cs_n: 2'b11, wdata: '0, rdata: '0,
        dior_n: 1'b1, diow_n: 1'b1
    };

    eng_t             eng_d, eng_q;
    logic             iordy_s;
    logic [CNT_W-1:0] strb_new, rcv_new;
    logic [1:0]       cs_new;
    logic             last_rcv, load, skip_setup, strobing;

    ide_pio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ide_iordy),
        .dout  (iordy_s)
    );

    ide_pio_timing #(.DRV_W(DRV_W)) u_timing (
        .fast_en   (cfg_fast_en),
        .strb_sel  (cfg_strb_sel),
        .rcv_sel   (cfg_rcv_sel),
        .drive     (req_drive),
        .data_port (req_data_port),
        .strb_last (strb_new),
        .rcv_last  (rcv_new)
    );

    assign cs_new     = req_ctl_blk ? 2'b01 : 2'b10;
    assign last_rcv   = (eng_q.phase == ST_RECOV) && (eng_q.cnt == '0);
    assign req_ready  = (eng_q.phase == ST_IDLE) || last_rcv;
    assign skip_setup = eng_q.dport && req_data_port &&
                        (req_addr == eng_q.da) && (cs_new == eng_q.cs_n);

    always_comb begin
        eng_d = eng_q;
        load  = 1'b0;
        unique case (eng_q.phase)
            ST_IDLE: begin
                if (req_valid) begin
                    load        = 1'b1;
                    eng_d.phase = ST_SETUP;
                    eng_d.cnt   = CNT_W'(SETUP_CLKS - 1);
                end
            end
            ST_SETUP: begin
                if (eng_q.cnt == '0) begin
                    eng_d.phase = ST_STRB;
                    eng_d.cnt   = eng_q.strb_last;
                end else begin
                    eng_d.cnt = eng_q.cnt - CNT_W'(1);
                end
            end
            ST_STRB, ST_WAIT: begin
                if (eng_q.cnt != '0) begin
                    eng_d.cnt = eng_q.cnt - CNT_W'(1);
                end else if (iordy_s) begin
                    eng_d.phase = ST_RECOV;
                    eng_d.cnt   = eng_q.rcv_last;
                    if (!eng_q.write) eng_d.rdata = ide_dd_in;
                end else if (eng_q.phase == ST_STRB) begin
                    eng_d.phase = ST_WAIT;
                    eng_d.cnt   = CNT_W'(WAIT_MIN - 1);
                end
            end
            ST_RECOV: begin
                if (eng_q.cnt != '0) begin
                    eng_d.cnt = eng_q.cnt - CNT_W'(1);
                end else if (req_valid) begin
                    load = 1'b1;
                    if (skip_setup) begin
                        eng_d.phase = ST_STRB;
                        eng_d.cnt   = strb_new;
                    end else begin
                        eng_d.phase = ST_SETUP;
                        eng_d.cnt   = CNT_W'(SETUP_CLKS - 1);
                    end
                end else begin
                    eng_d.phase = ST_IDLE;
                    eng_d.cs_n  = 2'b11;
                    eng_d.da    = '0;
                    eng_d.dport = 1'b0;
                    eng_d.write = 1'b0;
                end
            end
            default: eng_d.phase = ST_IDLE;
        endcase

        if (load) begin
            eng_d.write     = req_write;
            eng_d.dport     = req_data_port;
            eng_d.da        = req_addr;
            eng_d.cs_n      = cs_new;
            eng_d.wdata     = req_wdata;
            eng_d.strb_last = strb_new;
            eng_d.rcv_last  = rcv_new;
        end

        strobing     = (eng_d.phase == ST_STRB) || (eng_d.phase == ST_WAIT);
        eng_d.dior_n = !(strobing && !eng_d.write);
        eng_d.diow_n = !(strobing &&  eng_d.write);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= ENG_RST;
        else        eng_q <= eng_d;
    end

    assign ide_da     = eng_q.da;
    assign ide_cs_n   = eng_q.cs_n;
    assign ide_dior_n = eng_q.dior_n;
    assign ide_diow_n = eng_q.diow_n;
    assign ide_dd_out = eng_q.wdata;
    assign ide_dd_oe  = eng_q.write && (eng_q.phase != ST_IDLE);
    assign rsp_done   = last_rcv;
    assign rsp_rdata  = eng_q.rdata;
endmodule

// File: rtl/ide_pio_engine_chk.sv
module ide_pio_engine_chk #(
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] ide_da,
    input logic [1:0]        ide_cs_n,
    input logic              ide_dior_n,
    input logic              ide_diow_n,
    input logic              rsp_done
);
    logic strb_off;
    assign strb_off = ide_dior_n && ide_diow_n;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ide_dior_n && !ide_diow_n)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R4
    AST_SHUTDOWN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !req_valid) |=> (ide_cs_n == 2'b11)); // R12
    AST_LINES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_off && !$past(strb_off)) |-> ($stable(ide_da) && $stable(ide_cs_n))); // R2
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_off |-> ($countones(~ide_cs_n) == 1)); // R2
    AST_BUSY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_off |-> !req_ready); // R11
    AST_STROBE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_off) |=> !strb_off); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !rsp_done) |-> (strb_off && ide_cs_n == 2'b11)); // R1
endmodule

bind ide_pio_engine ide_pio_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .ide_da     (ide_da),
    .ide_cs_n   (ide_cs_n),
    .ide_dior_n (ide_dior_n),
    .ide_diow_n (ide_diow_n),
    .rsp_done   (rsp_done)
);

// File: tb/ide_pio_engine_bench.sv
`timescale 1ns/1ps
module ide_pio_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_data_port = 1'b0;
    logic [0:0]  req_drive = '0;
    logic        req_ctl_blk = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  cfg_fast_en = 2'b01;
    logic [3:0]  cfg_strb_sel = {2'd3, 2'd2};
    logic [3:0]  cfg_rcv_sel  = {2'd3, 2'd1};
    logic        req_ready, ide_dior_n, ide_diow_n, ide_dd_oe, rsp_done;
    logic [2:0]  ide_da;
    logic [1:0]  ide_cs_n;
    logic [15:0] ide_dd_out, rsp_rdata;
    logic [15:0] ide_dd_in = '0;
    logic        ide_iordy = 1'b1;
    int          total = 0, bad = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    ide_pio_engine u_ide_pio_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_data_port(req_data_port), .req_drive(req_drive),
        .req_ctl_blk(req_ctl_blk), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_fast_en(cfg_fast_en), .cfg_strb_sel(cfg_strb_sel), .cfg_rcv_sel(cfg_rcv_sel),
        .ide_da(ide_da), .ide_cs_n(ide_cs_n), .ide_dior_n(ide_dior_n),
        .ide_diow_n(ide_diow_n), .ide_dd_out(ide_dd_out), .ide_dd_oe(ide_dd_oe),
        .ide_dd_in(ide_dd_in), .ide_iordy(ide_iordy), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic        wr, dp, drv, ctl;
        logic [2:0]  addr;
        logic [15:0] wdata, rdin;
        logic [7:0]  lo;     // strobe clock on which IORDY returns high, 0 = never low
        logic        chain;  // next vector issued back to back
        logic [3:0]  su, st, rc;
    } vec_t;

    localparam int NV = 10;
    // table config: drive 0 fast, strobe 4, recovery 2; drive 1 compatible
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0,3'd0,16'h0000,16'h1234,8'd0,1'b0,4'd2,4'd4,4'd2},
        '{1'b1,1'b1,1'b0,1'b0,3'd0,16'hA5A5,16'h0000,8'd0,1'b1,4'd2,4'd4,4'd2},
        '{1'b0,1'b1,1'b0,1'b0,3'd0,16'h0000,16'hBEEF,8'd0,1'b1,4'd0,4'd4,4'd2},
        '{1'b1,1'b1,1'b1,1'b0,3'd0,16'h5A0F,16'h0000,8'd0,1'b0,4'd0,4'd5,4'd4},
        '{1'b0,1'b0,1'b0,1'b0,3'd7,16'h0000,16'h00C3,8'd0,1'b1,4'd2,4'd5,4'd4},
        '{1'b0,1'b0,1'b0,1'b0,3'd7,16'h0000,16'h003C,8'd0,1'b0,4'd2,4'd5,4'd4},
        '{1'b0,1'b1,1'b0,1'b0,3'd0,16'h0000,16'h7001,8'd3,1'b0,4'd2,4'd6,4'd2},
        '{1'b0,1'b1,1'b0,1'b0,3'd0,16'h0000,16'h7002,8'd8,1'b0,4'd2,4'd10,4'd2},
        '{1'b0,1'b1,1'b0,1'b0,3'd0,16'h0000,16'h7003,8'd2,1'b0,4'd2,4'd4,4'd2},
        '{1'b1,1'b0,1'b1,1'b1,3'd6,16'h0F0F,16'h0000,8'd0,1'b0,4'd2,4'd5,4'd4}
    };

    function automatic vec_t mk(logic wr, dp, drv, logic [15:0] rdin, logic chain,
                                int su, st, rc);
        vec_t v;
        v = '{wr, dp, drv, 1'b0, 3'd0, 16'hC001, rdin, 8'd0, chain,
              4'(su), 4'(st), 4'(rc)};
        return v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_req(vec_t v);
        req_write = v.wr; req_data_port = v.dp; req_drive = v.drv;
        req_ctl_blk = v.ctl; req_addr = v.addr; req_wdata = v.wdata;
        req_valid = 1'b1;
    endtask

    // precondition: request on the port, called at a falling edge
    task automatic run_txn(vec_t v, vec_t nx, string tg);
        int su = 0, st = 0, rc = 0, guard = 0;
        logic saw_rd = 1'b0, saw_wr = 1'b0, both = 1'b0, early = 1'b0, oe_s = 1'b0;
        logic [2:0]  da_s = '0;
        logic [1:0]  cs_s = 2'b11;
        logic [15:0] dq_s = '0, rd;
        string st_tag;
        ide_dd_in = v.rdin;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (guard < 100) begin
            guard++;
            if (!ide_dior_n || !ide_diow_n) begin
                st++;
                if (!ide_dior_n) saw_rd = 1'b1;
                if (!ide_diow_n) saw_wr = 1'b1;
                if (!ide_dior_n && !ide_diow_n) both = 1'b1;
                if (st == 1) begin
                    da_s = ide_da; cs_s = ide_cs_n; dq_s = ide_dd_out; oe_s = ide_dd_oe;
                end
                if (v.lo != 0 && st == 1) ide_iordy = 1'b0;
                if (v.lo != 0 && st == int'(v.lo)) ide_iordy = 1'b1;
            end else if (st == 0) begin
                su++;
            end else begin
                rc++;
                if (rc == 1 && v.chain) set_req(nx);
            end
            if (rsp_done) break;
            if (req_ready) early = 1'b1;
            @(negedge clk);
        end
        rd = rsp_rdata;
        ide_iordy = 1'b1;
        st_tag = (v.lo != 0) ? ((int'(v.st) > 5 || v.st > 4'd4) ? "R8 stretch" : "R9 no stretch")
               : (!v.dp ? "R5 compat" : (v.drv ? "R6 per drive" : "R3 fast"));
        chk({tg, (v.su == 0) ? " R7 no setup" : " R2 setup"}, su, int'(v.su));
        chk({tg, " ", st_tag, " strobe"}, st, int'(v.st));
        chk({tg, " R4 recovery"}, rc, int'(v.rc));
        chk({tg, " R10 strobe kind"}, int'(v.wr ? (saw_wr && !saw_rd) : (saw_rd && !saw_wr)), 1);
        chk({tg, " R10 exclusive"}, int'(both), 0);
        chk({tg, " R2 address"}, int'(da_s), int'(v.addr));
        chk({tg, " R2 select"}, int'(cs_s), v.ctl ? 1 : 2);
        if (v.wr) begin
            chk({tg, " R10 write data"}, int'(dq_s), int'(v.wdata));
            chk({tg, " R10 output enable"}, int'(oe_s), 1);
        end else begin
            chk({tg, " R10 read data"}, int'(rd), int'(v.rdin));
        end
        chk({tg, " R11 ready only at end"}, int'(early), 0);
        if (!v.chain) begin
            @(negedge clk);
            chk({tg, " R12 released"}, int'({ide_cs_n, rsp_done, req_ready}), 4'b1101);
        end
    endtask

    initial begin : main
        vec_t a, b;
        int guard;
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", int'({ide_dior_n, ide_diow_n}), 3);
        chk("R1 reset outputs", int'({ide_cs_n, rsp_done, req_ready}), 4'b1101);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", int'({ide_dior_n, ide_diow_n, ide_cs_n, rsp_done, req_ready}), 6'b111101);

        for (int i = 0; i < NV; i++) begin
            if (!(i > 0 && VECS[i-1].chain)) set_req(VECS[i]);
            run_txn(VECS[i], (i + 1 < NV) ? VECS[i+1] : VECS[i], $sformatf("vec%0d", i));
        end

        // R3 R4 lowest codes: strobe 2, recovery 1, then a chained pair
        cfg_strb_sel[1:0] = 2'd0; cfg_rcv_sel[1:0] = 2'd0;
        a = mk(1'b0, 1'b1, 1'b0, 16'h2222, 1'b1, 2, 2, 1);
        b = mk(1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 0, 2, 1);
        set_req(a); run_txn(a, b, "min_a");
        run_txn(b, b, "min_b");
        // R3 R4 highest codes: strobe 5, recovery 4
        cfg_strb_sel[1:0] = 2'd3; cfg_rcv_sel[1:0] = 2'd3;
        a = mk(1'b0, 1'b1, 1'b0, 16'h3333, 1'b0, 2, 5, 4);
        set_req(a); run_txn(a, a, "max");
        // R6 drive 1 enabled with its own codes, drive 0 keeps its own
        cfg_fast_en = 2'b11; cfg_strb_sel[3:2] = 2'd1; cfg_rcv_sel[3:2] = 2'd2;
        a = mk(1'b0, 1'b1, 1'b1, 16'h4444, 1'b0, 2, 3, 3);
        set_req(a); run_txn(a, a, "drv1");
        a = mk(1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 2, 5, 4);
        set_req(a); run_txn(a, a, "drv0");

        // R1 reset in the middle of a strobe
        a = mk(1'b0, 1'b1, 1'b0, 16'h5555, 1'b0, 2, 5, 4);
        set_req(a);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (ide_dior_n && guard < 20) begin @(negedge clk); guard++; end
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid cycle", int'({ide_dior_n, ide_diow_n, ide_cs_n, rsp_done, req_ready}), 6'b111101);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule